// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a 64-bit count of nanoseconds. It runs on a reference clock. On every enabled reference cycle the count grows by a programmed step plus one. A programmed step of 7, for example, suits a 125 MHz reference, where each cycle lasts 8 ns.

Frequency trim works by slipping or stretching the count. After a programmed number of reference cycles, one cycle adds a nanosecond more or a nanosecond less than usual. A direction bit chooses which. Setting that interval to the reference frequency divided by the wanted parts-per-billion gives the requested trim.

Software drives the block through a simple write port:
- It stages a new time in a low word and a high word, then commits it with a load strobe.
- It writes a push strobe to take a snapshot of the time. The snapshot leaves the block as a one-cycle event record with type 0, toward an event queue.

Top module: `nstime_core`

## Requirements
- R1: After reset, `time_ns` is 0 and `evt_valid` is low.
- R2: With control bit 0 set, the count grows by step+1 on each cycle. The step is the 3-bit value written to address 1, bits 2:0.
- R3: With control bit 0 clear (control is address 0), `time_ns` holds its value. Only a load changes it.
- R4: Writing address 2 (low word) or address 3 (high word) only stages a value and leaves `time_ns` alone. A write to address 4 with bit 0 set makes `time_ns` equal the staged value on the next cycle. The load wins over that cycle's increment.
- R5: A write to address 5 with bit 0 set raises `evt_valid` for exactly one cycle, on the next cycle, with `evt_type` = 0. `evt_time` holds the count as it stood in the strobe cycle, before that cycle's increment.
- R6: The trim interval is 42 bits wide. Address 6 holds bits 31:0 and address 7 holds bits 41:32 in its bits 9:0. With a non-zero interval N and control bit 7 clear, every N-th enabled cycle adds step+2.
- R7: With control bit 7 set, the correction cycle adds only step, so the count loses one nanosecond per interval.
- R8: An interval of zero turns trim off: every enabled cycle adds exactly step+1.
- R9: Any write to address 0, 6 or 7 restarts the interval count. The first correction after such a write falls on the N-th enabled cycle that follows.
- R10: With control bit 5 clear, the count runs as 32 bits:
  - From the next cycle on, bits 63:32 read zero.
  - This holds even after a load, and the low word wraps.
  - With bit 5 set, the carry propagates through all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| time_ns | output | 64 | Current nanosecond count |
| evt_valid | output | 1 | One-cycle event record valid |
| evt_type | output | 4 | Event type (0 = software push) |
| evt_time | output | 64 | Captured time of the event |

## Verification
The bench targets several corner cases, each tied to the fault it would expose:
- **Push capture.** The bench checks that a push captures the pre-increment count. A design that sampled after the add would report a time one step late.
- **Load priority.** It checks that a load replaces the count exactly in the strobe cycle. A design that added the step on top would come out one step high.
- **High interval word.** An interval is programmed with a non-zero high word, so a design that ignored bits 41:32 would correct every few cycles.
- **Interval restart.** The interval is rewritten partway through a count. A design that did not restart would slip one extra nanosecond too early.
- **Narrow-mode wrap.** The bench loads a value above 32 bits in narrow mode and then wraps the low word. This catches a missing mask on either the load path or the increment path.

// File: rtl/nstime_pkg.sv
package nstime_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_STEP    = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOAD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_LOAD_GO = 3'd4;
  localparam logic [ADDR_W-1:0] A_PUSH    = 3'd5;
  localparam logic [ADDR_W-1:0] A_TRIM_LO = 3'd6;
  localparam logic [ADDR_W-1:0] A_TRIM_HI = 3'd7;

  localparam int BIT_EN   = 0;
  localparam int BIT_WIDE = 5;
  localparam int BIT_DIR  = 7;

  localparam logic [3:0] EVT_SW_PUSH = 4'd0;

  // Increment for one cycle: step+1, plus or minus one on a correction cycle.
  function automatic logic [3:0] step_incr(input logic [2:0] step,
                                           input logic corr,
                                           input logic neg);
    logic [3:0] base;
    base = {1'b0, step} + 4'd1;
    if (corr && !neg) return base + 4'd1;
    if (corr && neg)  return base - 4'd1;
    return base;
  endfunction

  // Narrow mode keeps only the low word.
  function automatic logic [63:0] fit_width(input logic [63:0] v,
                                            input logic wide);
    return wide ? v : {32'd0, v[31:0]};
  endfunction

endpackage

// File: rtl/nstime_regs.sv
module nstime_regs
  import nstime_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int STEP_W = 3,
  parameter int TRIM_W = 42,
  localparam int TIME_W = 2 * WORD_W,
  localparam int TRIM_HI_W = TRIM_W - WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              cnt_en,
  output logic              wide_q,
  output logic              neg_q,
  output logic [STEP_W-1:0] step_q,
  output logic [TIME_W-1:0] load_val,
  output logic [TRIM_W-1:0] interval_q,
  output logic              load_go,
  output logic              push_go,
  output logic              trim_restart
);

  logic [WORD_W-1:0]    stage_lo, stage_hi;
  logic [WORD_W-1:0]    trim_lo;
  logic [TRIM_HI_W-1:0] trim_hi;

  logic hit_ctrl, hit_tlo, hit_thi;

  assign hit_ctrl = wr_en && (wr_addr == A_CTRL);
  assign hit_tlo  = wr_en && (wr_addr == A_TRIM_LO);
  assign hit_thi  = wr_en && (wr_addr == A_TRIM_HI);

  assign load_go      = wr_en && (wr_addr == A_LOAD_GO) && wr_data[0];
  assign push_go      = wr_en && (wr_addr == A_PUSH) && wr_data[0];
  assign trim_restart = hit_ctrl || hit_tlo || hit_thi;

  assign load_val   = {stage_hi, stage_lo};
  assign interval_q = {trim_hi, trim_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en   <= 1'b0;
      wide_q   <= 1'b0;
      neg_q    <= 1'b0;
      step_q   <= '0;
      stage_lo <= '0;
      stage_hi <= '0;
      trim_lo  <= '0;
      trim_hi  <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL: begin
          cnt_en <= wr_data[BIT_EN];
          wide_q <= wr_data[BIT_WIDE];
          neg_q  <= wr_data[BIT_DIR];
        end
        A_STEP:    step_q   <= wr_data[STEP_W-1:0];
        A_LOAD_LO: stage_lo <= wr_data;
        A_LOAD_HI: stage_hi <= wr_data;
        A_TRIM_LO: trim_lo  <= wr_data;
        A_TRIM_HI: trim_hi  <= wr_data[TRIM_HI_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nstime_trim.sv
module nstime_trim #(
  parameter int TRIM_W = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              restart,
  input  logic [TRIM_W-1:0] interval,
  output logic              corr_fire
);

  logic [TRIM_W-1:0] gap_cnt;
  logic              trim_on;

  assign trim_on   = cnt_en && (interval != '0);
  assign corr_fire = trim_on && (gap_cnt == interval - TRIM_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap_cnt <= '0;
    else if (restart) gap_cnt <= '0;
    else if (trim_on) gap_cnt <= corr_fire ? '0 : gap_cnt + TRIM_W'(1);
  end

endmodule

// File: rtl/nstime_count.sv
module nstime_count
  import nstime_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int STEP_W = 3,
  parameter int EVT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              wide_q,
  input  logic              neg_q,
  input  logic [STEP_W-1:0] step_q,
  input  logic              corr_fire,
  input  logic              load_go,
  input  logic [TIME_W-1:0] load_val,
  input  logic              push_go,
  output logic [TIME_W-1:0] time_q,
  output logic              evt_valid,
  output logic [EVT_W-1:0]  evt_type,
  output logic [TIME_W-1:0] evt_time
);

  logic [TIME_W-1:0] raw_next;
  logic [3:0]        incr;

  assign incr = step_incr(step_q, corr_fire, neg_q);

  always_comb begin
    if (load_go)     raw_next = load_val;
    else if (cnt_en) raw_next = time_q + TIME_W'(incr);
    else             raw_next = time_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q    <= '0;
      evt_valid <= 1'b0;
      evt_type  <= '0;
      evt_time  <= '0;
    end else begin
      time_q    <= fit_width(raw_next, wide_q);
      evt_valid <= push_go;
      if (push_go) begin
        evt_type <= EVT_W'(EVT_SW_PUSH);
        evt_time <= time_q;
      end
    end
  end

endmodule

// File: rtl/nstime_core.sv
module nstime_core
  import nstime_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int STEP_W = 3,
  parameter int TRIM_W = 42,
  parameter int EVT_W  = 4,
  localparam int TIME_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [TIME_W-1:0] time_ns,
  output logic              evt_valid,
  output logic [EVT_W-1:0]  evt_type,
  output logic [TIME_W-1:0] evt_time
);

  logic              cnt_en, wide_q, neg_q;
  logic [STEP_W-1:0] step_q;
  logic [TIME_W-1:0] load_val;
  logic [TRIM_W-1:0] interval_q;
  logic              load_go, push_go, trim_restart, corr_fire;

  nstime_regs #(.WORD_W(WORD_W), .STEP_W(STEP_W), .TRIM_W(TRIM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_en(cnt_en), .wide_q(wide_q), .neg_q(neg_q),
    .step_q(step_q), .load_val(load_val), .interval_q(interval_q),
    .load_go(load_go), .push_go(push_go), .trim_restart(trim_restart)
  );

  nstime_trim #(.TRIM_W(TRIM_W)) u_trim (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .restart(trim_restart),
    .interval(interval_q), .corr_fire(corr_fire)
  );

  nstime_count #(.TIME_W(TIME_W), .STEP_W(STEP_W), .EVT_W(EVT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wide_q(wide_q),
    .neg_q(neg_q), .step_q(step_q), .corr_fire(corr_fire),
    .load_go(load_go), .load_val(load_val), .push_go(push_go),
    .time_q(time_ns), .evt_valid(evt_valid), .evt_type(evt_type),
    .evt_time(evt_time)
  );

endmodule

// File: rtl/nstime_core_chk.sv
module nstime_core_chk #(
  parameter int TIME_W = 64,
  parameter int STEP_W = 3,
  parameter int EVT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              wide_q,
  input logic [STEP_W-1:0] step_q,
  input logic              load_go,
  input logic              push_go,
  input logic              corr_fire,
  input logic [TIME_W-1:0] load_val,
  input logic [TIME_W-1:0] time_ns,
  input logic              evt_valid,
  input logic [EVT_W-1:0]  evt_type,
  input logic [TIME_W-1:0] evt_time
);

  // R2
  plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && wide_q && !load_go && !corr_fire) |=>
      time_ns == $past(time_ns) + TIME_W'($past(step_q)) + TIME_W'(1));

  // R3
  hold_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load_go) |=> $stable(time_ns));

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && wide_q) |=> time_ns == $past(load_val));

  // R5
  push_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_go |=> (evt_valid && evt_type == '0 && evt_time == $past(time_ns)));

  // R5
  push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_go |=> !evt_valid);

  // R6
  corr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    corr_fire |-> cnt_en);

  // R10
  narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |=> time_ns[TIME_W-1:TIME_W/2] == '0);

endmodule

bind nstime_core nstime_core_chk #(
  .TIME_W(TIME_W), .STEP_W(STEP_W), .EVT_W(EVT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wide_q(wide_q),
  .step_q(step_q), .load_go(load_go), .push_go(push_go),
  .corr_fire(corr_fire), .load_val(load_val), .time_ns(time_ns),
  .evt_valid(evt_valid), .evt_type(evt_type), .evt_time(evt_time)
);

// File: tb/nstime_core_tb.sv
module nstime_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] time_ns;
  logic        evt_valid;
  logic [3:0]  evt_type;
  logic [63:0] evt_time;

  int vecs = 0;
  int miss = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nstime_core u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .time_ns(time_ns), .evt_valid(evt_valid),
    .evt_type(evt_type), .evt_time(evt_time)
  );

  task automatic chk(input string req, input logic [63:0] got,
                     input logic [63:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 time", time_ns, 64'd0);
    chk("R1 evt_valid", {63'd0, evt_valid}, 64'd0);
  endtask

  task automatic t_step;
    logic [63:0] t0;
    wr(3'd1, 32'd7);
    wr(3'd0, 32'h21);
    t0 = time_ns;
    idle(10);
    chk("R2 step7", time_ns, t0 + 64'd80);
    wr(3'd1, 32'd0);
    t0 = time_ns;
    idle(10);
    chk("R2 step0", time_ns, t0 + 64'd10);
  endtask

  task automatic t_disable;
    logic [63:0] t0;
    wr(3'd0, 32'h20);
    t0 = time_ns;
    idle(10);
    chk("R3 hold", time_ns, t0);
  endtask

  task automatic t_load;
    logic [63:0] t0;
    wr(3'd1, 32'd7);
    wr(3'd0, 32'h21);
    t0 = time_ns;
    wr(3'd2, 32'h89AB_CDEF);
    wr(3'd3, 32'h0123_4567);
    chk("R4 staging no effect", time_ns, t0 + 64'd16);
    wr(3'd4, 32'd1);
    chk("R4 load exact", time_ns, 64'h0123_4567_89AB_CDEF);
    idle(1);
    chk("R4 count after load", time_ns, 64'h0123_4567_89AB_CDF7);
  endtask

  task automatic t_push;
    logic [63:0] t0;
    t0 = time_ns;
    wr(3'd5, 32'd1);
    chk("R5 valid", {63'd0, evt_valid}, 64'd1);
    chk("R5 type", {60'd0, evt_type}, 64'd0);
    chk("R5 time pre-increment", evt_time, t0);
    chk("R5 counter moved on", time_ns, t0 + 64'd8);
    idle(1);
    chk("R5 one cycle", {63'd0, evt_valid}, 64'd0);
  endtask

  task automatic t_trim(input logic [31:0] ctrl, input logic [31:0] lo,
                        input logic [31:0] hi, input int cycles,
                        input logic [63:0] gain, input string req);
    logic [63:0] t0;
    wr(3'd1, 32'd3);
    wr(3'd6, lo);
    wr(3'd7, hi);
    wr(3'd0, ctrl);
    t0 = time_ns;
    idle(cycles);
    chk(req, time_ns, t0 + gain);
  endtask

  task automatic t_restart;
    logic [63:0] t0;
    wr(3'd1, 32'd3);
    wr(3'd6, 32'd5);
    wr(3'd7, 32'd0);
    wr(3'd0, 32'h21);
    idle(3);
    wr(3'd6, 32'd5);
    t0 = time_ns;
    idle(4);
    chk("R9 restart delays correction", time_ns, t0 + 64'd16);
    idle(1);
    chk("R9 correction after N", time_ns, t0 + 64'd21);
  endtask

  task automatic t_width;
    wr(3'd6, 32'd0);
    wr(3'd1, 32'd7);
    wr(3'd0, 32'h01);
    wr(3'd2, 32'hFFFF_FFF0);
    wr(3'd3, 32'h0000_0001);
    wr(3'd4, 32'd1);
    chk("R10 narrow load masked", time_ns, 64'h0000_0000_FFFF_FFF0);
    idle(3);
    chk("R10 narrow wrap", time_ns, 64'h0000_0000_0000_0008);
    wr(3'd0, 32'h21);
    wr(3'd2, 32'hFFFF_FFF8);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'd1);
    idle(1);
    chk("R10 wide carry", time_ns, 64'h0000_0001_0000_0000);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_step();
    t_disable();
    t_load();
    t_push();
    t_trim(32'h21, 32'd5, 32'd0, 20, 64'd84, "R6 positive trim");
    t_trim(32'hA1, 32'd5, 32'd0, 20, 64'd76, "R7 negative trim");
    t_trim(32'h21, 32'd0, 32'd0, 20, 64'd80, "R8 zero interval");
    t_trim(32'h21, 32'd3, 32'd1, 50, 64'd200, "R6 high word honoured");
    t_restart();
    t_width();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vecs++;
      miss++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

endmodule